// File: doc/BRIEF.md
# ULPI PHY Power Control Register Slice

This block is the part of a ULPI transceiver's register file that owns the power control byte. A simple one-cycle access strobe stands in for the ULPI bus turnaround. Each access carries a 6-bit immediate address, an 8-bit extended address and write data. The immediate value 2Fh is an escape: it tells the block to decode the extended address instead. Extended addresses 00h to 3Fh reach the same registers as the immediate ones. The power control byte answers at three aliases: one loads it, one sets bits, and one clears bits. All three return its value on a read.

The byte holds two edge enables for the B-session-valid input and a mode bit. The mode bit tells the pad logic whether the shared pin is an active-low reset input or an active-low power switch output. The B-session-valid input is asynchronous. It is synchronized, and each enabled edge becomes a one-cycle RXCMD request with the alternate interrupt flag raised. The RXCMD serializer reports through a busy input when it cannot take a request. An event that arrives during that time waits in a one-deep pending flag.

Top module: `ulpi_pwr_ctrl`

## Requirements
- R1: After reset the power control byte is 00h, `rxcmd_req` and `rd_valid` are low, and `pin_is_psw` is 0.
- R2: A write to effective address 3Dh loads the byte with the write data masked to the implemented bits 3, 2 and 0.
- R3: A write to effective address 3Eh sets every implemented bit whose write-data bit is 1 and leaves the others unchanged.
- R4: A write to effective address 3Fh clears every bit whose write-data bit is 1 and leaves the others unchanged.
- R5: A read strobe raises `rd_valid` on the next cycle. If the address is 3Dh, 3Eh or 3Fh, `rd_data` then holds the byte, and bits 7 to 4 and bit 1 always read 0.
- R6: Immediate address 2Fh takes the effective address from `acc_ext_addr`. Extended addresses 00h to 3Fh act exactly like the same immediate addresses.
- R7: Any other effective address leaves the byte unchanged and reads 00h. This covers immediate 19h to 2Eh, extended 40h to FFh and the other registers of the set.
- R8: If bit 2 is 1, a low-to-high change of `bvalid_async` produces a single `rxcmd_req` pulse with `rxcmd_alt_int` high. The pulse comes on the third rising clock edge after the change, when `rxcmd_busy` is low.
- R9: If bit 3 is 1, a high-to-low change of `bvalid_async` produces the same single pulse with the same timing.
- R10: An edge whose enable bit is 0 produces no request.
- R11: No request is issued in a cycle after `rxcmd_busy` was high. An event seen meanwhile is held and issued on the first edge with busy low.
- R12: `pin_is_psw` always equals bit 0 of the byte. 0 selects reset-input mode and 1 selects power-switch-output mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | One-cycle access strobe |
| acc_write | input | 1 | 1 selects write, 0 selects read |
| acc_imm_addr | input | 6 | Immediate register address |
| acc_ext_addr | input | 8 | Extended address, used when the immediate address is 2Fh |
| acc_wdata | input | 8 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read strobe |
| rd_data | output | 8 | Read data |
| bvalid_async | input | 1 | Asynchronous B-session-valid comparator output |
| rxcmd_busy | input | 1 | RXCMD serializer cannot take a request |
| rxcmd_req | output | 1 | One-cycle RXCMD request |
| rxcmd_alt_int | output | 1 | Alternate interrupt flag for the requested RXCMD |
| pin_is_psw | output | 1 | Shared pin mode: 0 reset input, 1 power switch output |

## Verification
A register operation changes the byte on the edge that samples the strobe. A read result appears one edge after its strobe, so the bench compares `rd_data` at the next falling edge. A change on `bvalid_async` passes through two synchronizer flops and one request flop, so the request is due on the third rising edge. The directed edge checks sample the falling edges before and after that one and expect low at both. Every cycle, a lockstep model built from the requirements advances in step with the design, and the bench compares outputs at the falling edge, half a period away from the edge where they change.

// File: rtl/ulpi_pwr_ctrl.sv
module ulpi_pwr_ctrl #(
  parameter logic [7:0] PWR_ADDR  = 8'h3D,
  parameter logic [5:0] ESC_ADDR  = 6'h2F,
  parameter logic [7:0] IMPL_MASK = 8'h0D,
  parameter int         FALL_BIT  = 3,
  parameter int         RISE_BIT  = 2,
  parameter int         MODE_BIT  = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_valid,
  input  logic       acc_write,
  input  logic [5:0] acc_imm_addr,
  input  logic [7:0] acc_ext_addr,
  input  logic [7:0] acc_wdata,
  output logic       rd_valid,
  output logic [7:0] rd_data,
  input  logic       bvalid_async,
  input  logic       rxcmd_busy,
  output logic       rxcmd_req,
  output logic       rxcmd_alt_int,
  output logic       pin_is_psw
);
  localparam logic [7:0] SET_ADDR = PWR_ADDR + 8'd1;
  localparam logic [7:0] CLR_ADDR = PWR_ADDR + 8'd2;

  logic [7:0] pwr_reg;
  logic [7:0] eff_addr;
  logic [7:0] wmask;
  logic       hit;
  logic       bv_s1, bv_s2, bv_prev;
  logic       ev_rise, ev_fall, ev;
  logic       pend, fire;

  assign eff_addr = (acc_imm_addr == ESC_ADDR) ? acc_ext_addr : {2'b00, acc_imm_addr};
  assign hit      = (eff_addr == PWR_ADDR) || (eff_addr == SET_ADDR) || (eff_addr == CLR_ADDR);
  assign wmask    = acc_wdata & IMPL_MASK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwr_reg <= '0;
    end else if (acc_valid && acc_write && hit) begin
      if (eff_addr == PWR_ADDR)      pwr_reg <= wmask;
      else if (eff_addr == SET_ADDR) pwr_reg <= pwr_reg | wmask;
      else                           pwr_reg <= pwr_reg & ~wmask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= acc_valid && !acc_write;
      if (acc_valid && !acc_write) rd_data <= hit ? pwr_reg : 8'h00;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bv_s1   <= 1'b0;
      bv_s2   <= 1'b0;
      bv_prev <= 1'b0;
    end else begin
      bv_s1   <= bvalid_async;
      bv_s2   <= bv_s1;
      bv_prev <= bv_s2;
    end
  end

  assign ev_rise = bv_s2 && !bv_prev && pwr_reg[RISE_BIT];
  assign ev_fall = !bv_s2 && bv_prev && pwr_reg[FALL_BIT];
  assign ev      = ev_rise || ev_fall;
  assign fire    = !rxcmd_busy && (ev || pend);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      rxcmd_req <= 1'b0;
    end else begin
      rxcmd_req <= fire;
      pend      <= rxcmd_busy ? (pend || ev) : (pend && ev);
    end
  end

  assign rxcmd_alt_int = rxcmd_req;
  assign pin_is_psw    = pwr_reg[MODE_BIT];

  a_r7_unimpl_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && !hit) |=> $stable(pwr_reg));
  a_r7_unimpl_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && !hit) |=> (rd_data == 8'h00));
  a_r5_rd_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write) |=> rd_valid);
  a_r5_reserved_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ((rd_data & ~IMPL_MASK) == 8'h00));
  a_r11_no_req_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rxcmd_busy |=> !rxcmd_req);
  a_r8_rise_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (bv_s2 && !bv_prev && pwr_reg[RISE_BIT] && !rxcmd_busy) |=> (rxcmd_req && rxcmd_alt_int));
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev && !pend) |=> !rxcmd_req);
endmodule

// File: tb/tb_ulpi_pwr_ctrl.sv
module tb_ulpi_pwr_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       acc_valid, acc_write;
  logic [5:0] acc_imm_addr;
  logic [7:0] acc_ext_addr, acc_wdata;
  logic       rd_valid;
  logic [7:0] rd_data;
  logic       bvalid_async, rxcmd_busy;
  logic       rxcmd_req, rxcmd_alt_int, pin_is_psw;

  always #10 clk = ~clk;

  ulpi_pwr_ctrl dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_imm_addr(acc_imm_addr), .acc_ext_addr(acc_ext_addr), .acc_wdata(acc_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .bvalid_async(bvalid_async),
    .rxcmd_busy(rxcmd_busy), .rxcmd_req(rxcmd_req), .rxcmd_alt_int(rxcmd_alt_int),
    .pin_is_psw(pin_is_psw)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [7:0] m_reg, m_rdd;
  logic m_s1, m_s2, m_prev, m_pend, m_req, m_rdv;
  logic bv_lvl = 1'b0, busy_lvl = 1'b0;

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] eff(logic [5:0] imm, logic [7:0] ext);
    return (imm == 6'h2F) ? ext : {2'b00, imm};
  endfunction

  function automatic logic [7:0] next_reg(logic [7:0] cur, logic [7:0] ea, logic [7:0] wd);
    case (ea)
      8'h3D:   return wd & 8'h0D;
      8'h3E:   return cur | (wd & 8'h0D);
      8'h3F:   return cur & ~wd;
      default: return cur;
    endcase
  endfunction

  function automatic logic [7:0] rd_val(logic [7:0] cur, logic [7:0] ea);
    return (ea >= 8'h3D && ea <= 8'h3F) ? cur : 8'h00;
  endfunction

  task automatic cyc(logic v, logic w, logic [5:0] imm, logic [7:0] ext, logic [7:0] wd);
    logic [7:0] ea;
    logic ev;
    @(negedge clk);
    chk("R8 R9 R10 R11 req", {7'd0, rxcmd_req}, {7'd0, m_req});
    chk("R8 alt_int", {7'd0, rxcmd_alt_int}, {7'd0, m_req});
    chk("R5 rd_valid", {7'd0, rd_valid}, {7'd0, m_rdv});
    if (m_rdv) chk("R5 R6 R7 rd_data", rd_data, m_rdd);
    chk("R12 pin mode", {7'd0, pin_is_psw}, {7'd0, m_reg[0]});
    acc_valid = v; acc_write = w; acc_imm_addr = imm; acc_ext_addr = ext; acc_wdata = wd;
    bvalid_async = bv_lvl; rxcmd_busy = busy_lvl;
    ea = eff(imm, ext);
    ev = (m_s2 & ~m_prev & m_reg[2]) | (~m_s2 & m_prev & m_reg[3]);
    m_req  = ~busy_lvl & (ev | m_pend);
    m_pend = busy_lvl ? (m_pend | ev) : (m_pend & ev);
    m_rdv  = v & ~w;
    if (v && !w) m_rdd = rd_val(m_reg, ea);
    if (v && w) m_reg = next_reg(m_reg, ea, wd);
    m_prev = m_s2; m_s2 = m_s1; m_s1 = bv_lvl;
  endtask

  task automatic idle();
    cyc(1'b0, 1'b0, 6'h00, 8'h00, 8'h00);
  endtask

  task automatic rd_check(logic [5:0] imm, logic [7:0] ext, logic [7:0] exp, string tag);
    cyc(1'b1, 1'b0, imm, ext, 8'h00);
    idle();
    chk(tag, rd_data, exp);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1507));
    rst_n = 1'b0; acc_valid = 0; acc_write = 0; acc_imm_addr = 0; acc_ext_addr = 0;
    acc_wdata = 0; bvalid_async = 0; rxcmd_busy = 0;
    m_reg = 0; m_rdd = 0; m_s1 = 0; m_s2 = 0; m_prev = 0; m_pend = 0; m_req = 0; m_rdv = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 reset req", {7'd0, rxcmd_req}, 8'h00);
    chk("R1 reset rd_valid", {7'd0, rd_valid}, 8'h00);
    chk("R1 reset pin", {7'd0, pin_is_psw}, 8'h00);
    rd_check(6'h3D, 8'h00, 8'h00, "R1 reset value");

    cyc(1'b1, 1'b1, 6'h3D, 8'h00, 8'hFF);
    rd_check(6'h3E, 8'h00, 8'h0D, "R2 load masked, R5 reserved zero");
    chk("R12 psw mode", {7'd0, pin_is_psw}, 8'h01);
    cyc(1'b1, 1'b1, 6'h3F, 8'h00, 8'h05);
    rd_check(6'h3F, 8'h00, 8'h08, "R4 clear");
    cyc(1'b1, 1'b1, 6'h3E, 8'h00, 8'h04);
    rd_check(6'h3D, 8'h00, 8'h0C, "R3 set");
    cyc(1'b1, 1'b1, 6'h2F, 8'h3D, 8'h01);
    rd_check(6'h2F, 8'h3E, 8'h01, "R6 extended alias");
    cyc(1'b1, 1'b1, 6'h1A, 8'h00, 8'h0D);
    rd_check(6'h3D, 8'h00, 8'h01, "R7 imm 1Ah no effect");
    cyc(1'b1, 1'b1, 6'h2F, 8'h7D, 8'h0C);
    rd_check(6'h3D, 8'h00, 8'h01, "R7 ext 7Dh no effect");
    rd_check(6'h2F, 8'hBD, 8'h00, "R7 ext read zero");
    rd_check(6'h20, 8'h00, 8'h00, "R7 imm read zero");

    cyc(1'b1, 1'b1, 6'h3D, 8'h00, 8'h04);
    bv_lvl = 1'b1;
    idle();
    idle(); chk("R8 not before third edge", {7'd0, rxcmd_req}, 8'h00);
    idle(); chk("R8 not before third edge", {7'd0, rxcmd_req}, 8'h00);
    idle(); chk("R8 rise pulse", {7'd0, rxcmd_req}, 8'h01);
    chk("R8 alt int", {7'd0, rxcmd_alt_int}, 8'h01);
    idle(); chk("R8 single pulse", {7'd0, rxcmd_req}, 8'h00);
    bv_lvl = 1'b0;
    repeat (6) begin
      idle(); chk("R10 disabled fall", {7'd0, rxcmd_req}, 8'h00);
    end
    cyc(1'b1, 1'b1, 6'h3D, 8'h00, 8'h08);
    bv_lvl = 1'b1; repeat (5) idle();
    busy_lvl = 1'b1; bv_lvl = 1'b0;
    repeat (6) begin
      idle(); chk("R11 held while busy", {7'd0, rxcmd_req}, 8'h00);
    end
    busy_lvl = 1'b0;
    idle();
    idle(); chk("R9 R11 pending released", {7'd0, rxcmd_req}, 8'h01);
    idle(); chk("R11 one pulse only", {7'd0, rxcmd_req}, 8'h00);

    for (int i = 0; i < 4000; i++) begin
      logic [5:0] imm;
      logic [7:0] ext;
      case ($urandom % 6)
        0: imm = 6'h3D; 1: imm = 6'h3E; 2: imm = 6'h3F; 3: imm = 6'h2F;
        default: imm = 6'($urandom);
      endcase
      case ($urandom % 5)
        0: ext = 8'h3D; 1: ext = 8'h3E; 2: ext = 8'h3F; 3: ext = 8'h7F;
        default: ext = 8'($urandom);
      endcase
      if ($urandom % 6 == 0) bv_lvl = ~bv_lvl;
      busy_lvl = ($urandom % 4 == 0);
      cyc(($urandom % 3) == 0, $urandom % 2 == 0, imm, ext, 8'($urandom));
    end
    busy_lvl = 1'b0;
    repeat (5) idle();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule